// File: doc/BRIEF.md
# LRU Fence Slot Allocator

This block keeps a small pool of tiling-window slots in least-recently-used order and hands them out on request. Every slot has a pin count and an owner-busy flag that comes from outside the block. A requester that already owns a slot refreshes it: the pin count goes up and the slot becomes the most recently used one. A requester that needs a new slot starts a victim search. The search walks the list from the LRU end, prefers slots whose owner is idle, and never takes a pinned slot.

A slot can also be reserved for exclusive use, which takes it out of the pool. It can be released again later, and it then re-enters at the LRU end. Each request ends with a one-cycle done pulse carrying a 2-bit status and the slot concerned. A separate unpin input lowers pin counts and raises a sticky error flag on underflow. Programming the tiling registers and moving data are left to other blocks.

Top module: `fence_lru_alloc`

## Requirements
- R1: After reset every slot is in the pool, unpinned, and ordered by index with slot 0 least recently used. `readyOut` is 1, and both `doneOut` and `pinErr` are 0.
- R2: An acquire (reqOp=0) grants the first idle unpinned slot in LRU order with status ok (0). It adds one to that slot's pin count and moves the slot to the MRU end.
- R3: During a search, a slot whose `busyIn` bit is 1 is moved to the MRU end and skipped, and the first such slot is remembered. When the remembered slot comes up again, busy bits are no longer honoured, and the walk takes the next unpinned slot whether busy or not.
- R4: A slot with a nonzero pin count is never granted by a search.
- R5: A search that finds no slot ends with status retry (1) if `pendingRelease` is 1 in its final cycle, and with no-buffers (2) otherwise.
- R6: A refresh (reqOp=1) of slot `reqSlot` adds one to its pin count and moves it to the MRU end if it is in the pool. It does no search and completes with status ok, with `grantOut` equal to `reqSlot`.
- R7: A reserve (reqOp=2) completes with no-space (3) unless at least two pool slots are unpinned. Otherwise it runs the R3 search. A successful reserve removes the chosen slot from the pool without touching its pin count.
- R8: A release (reqOp=3) puts `reqSlot` back into the pool at the LRU end and completes with status ok. Releasing a slot that is already in the pool changes nothing.
- R9: An unpin pulse lowers the named slot's pin count. Unpinning a slot whose count is zero leaves the count at zero and sets `pinErr`, which stays set until reset.
- R10: A search examines one list position per clock, and `readyOut` is 0 while it runs. Requests that arrive while `readyOut` is 0 are ignored. A request accepted with `readyOut` high produces `doneOut` for one cycle, S+1 cycles after acceptance, where S is the number of positions examined plus one if the walk runs off the end of the list. Refresh, release and no-space complete with S=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when readyOut is 1 |
| reqOp | input | 2 | 0 acquire, 1 refresh, 2 reserve, 3 release |
| reqSlot | input | $clog2(NUM_SLOTS) | Slot for refresh and release |
| busyIn | input | NUM_SLOTS | Owner-busy flag per slot |
| pendingRelease | input | 1 | A slot release is expected soon; failed searches report retry |
| unpinValid | input | 1 | Unpin strobe |
| unpinSlot | input | $clog2(NUM_SLOTS) | Slot whose pin count is lowered |
| readyOut | output | 1 | No search in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| statusOut | output | 2 | 0 ok, 1 retry, 2 no-buffers, 3 no-space |
| grantOut | output | $clog2(NUM_SLOTS) | Slot granted, refreshed or released |
| pinErr | output | 1 | Sticky pin-count underflow flag |

## Verification
The bench goes after searches where every slot is busy. A design that never wraps would then fail or loop, and one that drops the remembered slot would grant the wrong victim. It also covers the case where all slots are pinned while some are busy, which must end in retry or no-buffers after exactly the right number of rotations. The reserve threshold is tested at one and at two free slots, and an off-by-one there turns a no-space into a grant. The bench also releases a reserved slot twice and drives requests during a search: a design that re-inserts the slot or accepts the stray refresh corrupts the list order or the pin counts, and later grants then differ from the model.

// File: rtl/fence_lru_pkg.sv
package fence_lru_pkg;

  typedef enum logic [1:0] {
    OP_ACQUIRE = 2'd0,
    OP_REFRESH = 2'd1,
    OP_RESERVE = 2'd2,
    OP_RELEASE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_RETRY   = 2'd1,
    ST_NOBUF   = 2'd2,
    ST_NOSPACE = 2'd3
  } status_e;

  // strobes from control to the list/pin datapath; at most one list op per cycle
  typedef struct packed {
    logic moveTail;    // entry at cmdPos goes to the MRU end
    logic removeAt;    // entry at cmdPos leaves the pool
    logic insertHead;  // cmdSlot enters the pool at the LRU end
    logic pinInc;      // pin count of cmdSlot goes up by one
  } dp_cmd_t;

endpackage

// File: rtl/fence_lru_dp.sv
module fence_lru_dp
  import fence_lru_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PIN_W     = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dp_cmd_t              cmd,
  input  logic [SLOT_W-1:0]    cmdPos,
  input  logic [SLOT_W-1:0]    cmdSlot,
  input  logic [SLOT_W-1:0]    lookPos,
  input  logic [SLOT_W-1:0]    findSlot,
  input  logic                 unpinValid,
  input  logic [SLOT_W-1:0]    unpinSlot,
  output logic [SLOT_W-1:0]    lookSlot,
  output logic                 findHit,
  output logic [SLOT_W-1:0]    findPos,
  output logic [CNT_W-1:0]     listLen,
  output logic [NUM_SLOTS-1:0] unpinnedMask,
  output logic [NUM_SLOTS-1:0] poolMask,
  output logic                 pinErr
);

  logic [SLOT_W-1:0]    order     [NUM_SLOTS];
  logic [SLOT_W-1:0]    orderNext [NUM_SLOTS];
  logic [CNT_W-1:0]     len, lenNext;
  logic [NUM_SLOTS-1:0] pool, poolNext;
  logic [SLOT_W-1:0]    tailIdx;
  logic                 errQ;

  assign tailIdx = SLOT_W'(len - 1'b1);

  // list next state: shift-left for tail move / removal, shift-right for head insert
  always_comb begin
    orderNext = order;
    lenNext   = len;
    poolNext  = pool;
    if (cmd.moveTail) begin
      for (int i = 0; i < NUM_SLOTS - 1; i++)
        if (SLOT_W'(i) >= cmdPos && CNT_W'(i + 1) < len) orderNext[i] = order[i+1];
      orderNext[tailIdx] = order[cmdPos];
    end else if (cmd.removeAt) begin
      for (int i = 0; i < NUM_SLOTS - 1; i++)
        if (SLOT_W'(i) >= cmdPos && CNT_W'(i + 1) < len) orderNext[i] = order[i+1];
      lenNext = len - 1'b1;
      poolNext[order[cmdPos]] = 1'b0;
    end else if (cmd.insertHead) begin
      for (int i = 1; i < NUM_SLOTS; i++)
        if (CNT_W'(i) <= len) orderNext[i] = order[i-1];
      orderNext[0] = cmdSlot;
      lenNext = len + 1'b1;
      poolNext[cmdSlot] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) order[i] <= SLOT_W'(i);
      len  <= CNT_W'(NUM_SLOTS);
      pool <= '1;
    end else begin
      order <= orderNext;
      len   <= lenNext;
      pool  <= poolNext;
    end
  end

  // per-slot pin counters
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pin
    logic [PIN_W-1:0] cnt;
    logic             incHit, decHit;
    assign incHit = cmd.pinInc && (cmdSlot == SLOT_W'(s));
    assign decHit = unpinValid && (unpinSlot == SLOT_W'(s)) && (cnt != '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (incHit && !decHit) cnt <= cnt + 1'b1;
      else if (decHit && !incHit) cnt <= cnt - 1'b1;
    end
    assign unpinnedMask[s] = (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   errQ <= 1'b0;
    else if (unpinValid && unpinnedMask[unpinSlot]) errQ <= 1'b1;
  end

  always_comb begin
    findHit = 1'b0;
    findPos = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (CNT_W'(i) < len && order[i] == findSlot) begin
        findHit = 1'b1;
        findPos = SLOT_W'(i);
      end
  end

  assign lookSlot = order[lookPos];
  assign listLen  = len;
  assign poolMask = pool;
  assign pinErr   = errQ;

endmodule

// File: rtl/fence_lru_ctl.sv
module fence_lru_ctl
  import fence_lru_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [SLOT_W-1:0]    reqSlot,
  input  logic [NUM_SLOTS-1:0] busyIn,
  input  logic                 pendingRelease,
  input  logic [SLOT_W-1:0]    lookSlot,
  input  logic                 findHit,
  input  logic [SLOT_W-1:0]    findPos,
  input  logic [CNT_W-1:0]     listLen,
  input  logic [NUM_SLOTS-1:0] unpinnedMask,
  input  logic [NUM_SLOTS-1:0] poolMask,
  output dp_cmd_t              cmd,
  output logic [SLOT_W-1:0]    cmdPos,
  output logic [SLOT_W-1:0]    cmdSlot,
  output logic [SLOT_W-1:0]    lookPos,
  output logic                 readyOut,
  output logic                 doneOut,
  output logic [1:0]           statusOut,
  output logic [SLOT_W-1:0]    grantOut
);

  typedef enum logic {S_IDLE, S_SEARCH} state_e;

  state_e            state;
  logic              isReserve;
  logic [CNT_W-1:0]  pos;
  logic              remValid, wrapped;
  logic [SLOT_W-1:0] remSlot;
  logic              doneQ;
  status_e           statusQ;
  logic [SLOT_W-1:0] grantQ;

  logic              finish, startSearch, startReserve, posInc, remember, wrapNow;
  status_e           finStatus;
  logic [SLOT_W-1:0] finGrant;
  logic [CNT_W-1:0]  freeCnt;

  always_comb begin
    freeCnt = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (unpinnedMask[i] && poolMask[i]) freeCnt = freeCnt + 1'b1;
  end

  assign lookPos = SLOT_W'(pos);
  assign wrapNow = wrapped || (remValid && lookSlot == remSlot);

  always_comb begin
    cmd          = '0;
    cmdPos       = SLOT_W'(pos);
    cmdSlot      = lookSlot;
    finish       = 1'b0;
    finStatus    = ST_OK;
    finGrant     = lookSlot;
    startSearch  = 1'b0;
    startReserve = 1'b0;
    posInc       = 1'b0;
    remember     = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          case (op_e'(reqOp))
            OP_REFRESH: begin
              cmd.pinInc = 1'b1;
              cmdSlot    = reqSlot;
              if (findHit) begin
                cmd.moveTail = 1'b1;
                cmdPos       = findPos;
              end
              finish   = 1'b1;
              finGrant = reqSlot;
            end
            OP_RELEASE: begin
              if (!poolMask[reqSlot]) begin
                cmd.insertHead = 1'b1;
                cmdSlot        = reqSlot;
              end
              finish   = 1'b1;
              finGrant = reqSlot;
            end
            OP_RESERVE: begin
              if (freeCnt < CNT_W'(2)) begin
                finish    = 1'b1;
                finStatus = ST_NOSPACE;
                finGrant  = '0;
              end else begin
                startSearch  = 1'b1;
                startReserve = 1'b1;
              end
            end
            default: startSearch = 1'b1;
          endcase
        end
      end
      S_SEARCH: begin
        if (pos >= listLen) begin
          finish    = 1'b1;
          finStatus = pendingRelease ? ST_RETRY : ST_NOBUF;
          finGrant  = '0;
        end else if (!wrapNow && busyIn[lookSlot]) begin
          cmd.moveTail = 1'b1;
          remember     = !remValid;
        end else if (!unpinnedMask[lookSlot]) begin
          posInc = 1'b1;
        end else begin
          finish = 1'b1;
          if (isReserve) cmd.removeAt = 1'b1;
          else begin
            cmd.moveTail = 1'b1;
            cmd.pinInc   = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      isReserve <= 1'b0;
      pos       <= '0;
      remValid  <= 1'b0;
      remSlot   <= '0;
      wrapped   <= 1'b0;
      doneQ     <= 1'b0;
      statusQ   <= ST_OK;
      grantQ    <= '0;
    end else begin
      doneQ <= finish;
      if (finish) begin
        statusQ <= finStatus;
        grantQ  <= finGrant;
      end
      case (state)
        S_IDLE: begin
          if (startSearch) begin
            state     <= S_SEARCH;
            isReserve <= startReserve;
            pos       <= '0;
            remValid  <= 1'b0;
            wrapped   <= 1'b0;
          end
        end
        default: begin
          wrapped <= wrapNow;
          if (posInc) pos <= pos + 1'b1;
          if (remember) begin
            remValid <= 1'b1;
            remSlot  <= lookSlot;
          end
          if (finish) state <= S_IDLE;
        end
      endcase
    end
  end

  assign readyOut  = (state == S_IDLE);
  assign doneOut   = doneQ;
  assign statusOut = statusQ;
  assign grantOut  = grantQ;

endmodule

// File: rtl/fence_lru_alloc.sv
module fence_lru_alloc
  import fence_lru_pkg::*;
#(
  parameter  int NUM_SLOTS = 8,
  parameter  int PIN_W     = 4,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [SLOT_W-1:0]    reqSlot,
  input  logic [NUM_SLOTS-1:0] busyIn,
  input  logic                 pendingRelease,
  input  logic                 unpinValid,
  input  logic [SLOT_W-1:0]    unpinSlot,
  output logic                 readyOut,
  output logic                 doneOut,
  output logic [1:0]           statusOut,
  output logic [SLOT_W-1:0]    grantOut,
  output logic                 pinErr
);

  dp_cmd_t              cmd;
  logic [SLOT_W-1:0]    cmdPos, cmdSlot, lookPos, lookSlot, findPos;
  logic                 findHit;
  logic [CNT_W-1:0]     listLen;
  logic [NUM_SLOTS-1:0] unpinnedMask, poolMask;

  fence_lru_ctl #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqOp(reqOp), .reqSlot(reqSlot),
    .busyIn(busyIn), .pendingRelease(pendingRelease),
    .lookSlot(lookSlot), .findHit(findHit), .findPos(findPos),
    .listLen(listLen), .unpinnedMask(unpinnedMask), .poolMask(poolMask),
    .cmd(cmd), .cmdPos(cmdPos), .cmdSlot(cmdSlot), .lookPos(lookPos),
    .readyOut(readyOut), .doneOut(doneOut), .statusOut(statusOut),
    .grantOut(grantOut)
  );

  fence_lru_dp #(
    .NUM_SLOTS(NUM_SLOTS), .PIN_W(PIN_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .cmd(cmd), .cmdPos(cmdPos), .cmdSlot(cmdSlot), .lookPos(lookPos),
    .findSlot(reqSlot), .unpinValid(unpinValid), .unpinSlot(unpinSlot),
    .lookSlot(lookSlot), .findHit(findHit), .findPos(findPos),
    .listLen(listLen), .unpinnedMask(unpinnedMask), .poolMask(poolMask),
    .pinErr(pinErr)
  );

endmodule

// File: rtl/fence_lru_chk.sv
module fence_lru_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reqValid,
  input logic [1:0]           reqOp,
  input logic [SLOT_W-1:0]    reqSlot,
  input logic                 readyOut,
  input logic                 doneOut,
  input logic [1:0]           statusOut,
  input logic [SLOT_W-1:0]    grantOut,
  input logic                 pinErr,
  input logic [NUM_SLOTS-1:0] unpinnedMask,
  input logic [NUM_SLOTS-1:0] poolMask
);

  logic [NUM_SLOTS-1:0] prevUnpinned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevUnpinned <= '1;
    else        prevUnpinned <= unpinnedMask;
  end

  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |-> readyOut);

  // R10
  search_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(readyOut) |-> $past(reqValid));

  // R4
  victim_unpinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneOut && statusOut == 2'd0 && !$past(readyOut)) |-> prevUnpinned[grantOut]);

  // R6
  refresh_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readyOut && reqValid && reqOp == 2'd1) |=>
      (doneOut && statusOut == 2'd0 && grantOut == $past(reqSlot)));

  // R8
  release_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readyOut && reqValid && reqOp == 2'd3) |=>
      (doneOut && statusOut == 2'd0 && grantOut == $past(reqSlot)));

  // R7
  nospace_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneOut && statusOut == 2'd3) |-> ($past($countones(unpinnedMask & poolMask)) < 2));

  // R9
  pin_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pinErr |=> pinErr);

endmodule

bind fence_lru_alloc fence_lru_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqSlot(reqSlot),
  .readyOut(readyOut), .doneOut(doneOut), .statusOut(statusOut), .grantOut(grantOut),
  .pinErr(pinErr), .unpinnedMask(unpinnedMask), .poolMask(poolMask)
);

// File: tb/fence_lru_alloc_tb.sv
module fence_lru_alloc_tb;
  localparam int N  = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'd0;
  logic [SW-1:0] reqSlot = '0;
  logic [N-1:0]  busyIn = '0;
  logic          pendingRelease = 1'b0;
  logic          unpinValid = 1'b0;
  logic [SW-1:0] unpinSlot = '0;
  logic          readyOut, doneOut, pinErr;
  logic [1:0]    statusOut;
  logic [SW-1:0] grantOut;

  always #2 clk = ~clk;

  fence_lru_alloc #(.NUM_SLOTS(N), .PIN_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqSlot(reqSlot),
    .busyIn(busyIn), .pendingRelease(pendingRelease), .unpinValid(unpinValid),
    .unpinSlot(unpinSlot), .readyOut(readyOut), .doneOut(doneOut),
    .statusOut(statusOut), .grantOut(grantOut), .pinErr(pinErr)
  );

  int tests = 0;
  int fails = 0;
  int lst[$];
  int pin[N];
  bit errM = 1'b0;
  bit strayOn = 1'b0;
  int lastGrant = 0;

  task automatic checkEq(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural victim walk over the LRU queue
  task automatic modelSearch(bit rsv, output int st, output int gr, output int steps);
    int i = 0;
    int rem = -1;
    bit wr = 1'b0;
    int e;
    steps = 0;
    st = 0;
    gr = 0;
    while (1) begin
      steps++;
      if (i >= lst.size()) begin
        st = pendingRelease ? 1 : 2;
        return;
      end
      e = lst[i];
      if (rem >= 0 && e == rem) wr = 1'b1;
      if (!wr && busyIn[e]) begin
        if (rem < 0) rem = e;
        lst.delete(i);
        lst.push_back(e);
      end else if (pin[e] != 0) begin
        i++;
      end else begin
        lst.delete(i);
        if (!rsv) begin
          pin[e]++;
          lst.push_back(e);
        end
        gr = e;
        return;
      end
    end
  endtask

  task automatic runOp(int op, int slot, string tag);
    int st, gr, steps, idx, free;
    st = 0; gr = slot; steps = 0;
    case (op)
      1: begin
        pin[slot]++;
        idx = -1;
        foreach (lst[i]) if (lst[i] == slot) idx = i;
        if (idx >= 0) begin lst.delete(idx); lst.push_back(slot); end
      end
      3: begin
        idx = -1;
        foreach (lst[i]) if (lst[i] == slot) idx = i;
        if (idx < 0) lst.push_front(slot);
      end
      2: begin
        free = 0;
        foreach (lst[i]) if (pin[lst[i]] == 0) free++;
        if (free < 2) st = 3;
        else modelSearch(1'b1, st, gr, steps);
      end
      default: modelSearch(1'b0, st, gr, steps);
    endcase
    lastGrant = gr;
    checkEq("R10", "ready before request", int'(readyOut), 1);
    reqValid = 1'b1;
    reqOp    = op[1:0];
    reqSlot  = slot[SW-1:0];
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < steps; k++) begin
      checkEq("R10", "done during search", int'(doneOut), 0);
      checkEq("R10", "ready during search", int'(readyOut), 0);
      if (strayOn) begin
        reqValid = 1'b1;
        reqOp    = 2'd1;
        reqSlot  = SW'(k);
      end
      @(posedge clk); @(negedge clk);
    end
    reqValid = 1'b0;
    checkEq(tag, "done pulse", int'(doneOut), 1);
    checkEq(tag, "status", int'(statusOut), st);
    if (st == 0) checkEq(tag, "slot", int'(grantOut), gr);
  endtask

  task automatic doUnpin(int s);
    if (pin[s] == 0) errM = 1'b1;
    else pin[s]--;
    unpinValid = 1'b1;
    unpinSlot  = SW'(s);
    @(posedge clk); @(negedge clk);
    unpinValid = 1'b0;
    checkEq("R9", "error flag", int'(pinErr), int'(errM));
  endtask

  initial begin
    int rsv, r, s, z;
    for (int i = 0; i < N; i++) begin pin[i] = 0; lst.push_back(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checkEq("R1", "ready after reset", int'(readyOut), 1);
    checkEq("R1", "done after reset", int'(doneOut), 0);
    checkEq("R1", "pinErr after reset", int'(pinErr), 0);

    runOp(0, 0, "R1");            // index order: slot 0 first
    runOp(0, 0, "R2");            // then slot 1
    doUnpin(0);
    doUnpin(1);
    busyIn = 8'b0000_1100;
    runOp(0, 0, "R3");            // 2 and 3 rotated, 4 granted
    busyIn = '1;
    runOp(0, 0, "R3");            // all busy: wrap to first remembered
    busyIn = '0;
    repeat (8) runOp(0, 0, "R4"); // fill the pool, then fail
    pendingRelease = 1'b1;
    runOp(0, 0, "R5");
    pendingRelease = 1'b0;
    runOp(0, 0, "R5");
    busyIn = 8'b1010_0000;
    runOp(0, 0, "R5");            // all pinned with busy rotations
    busyIn = '0;

    runOp(2, 0, "R7");            // no unpinned slot
    doUnpin(3);
    runOp(2, 0, "R7");            // one unpinned slot
    doUnpin(6);
    runOp(2, 0, "R7");            // two unpinned: success
    rsv = lastGrant;
    runOp(2, 0, "R7");            // one left in pool
    doUnpin(2);
    runOp(0, 0, "R7");            // reserved slot must not be granted
    runOp(3, rsv, "R8");
    runOp(3, rsv, "R8");          // already in pool: no effect
    runOp(0, 0, "R8");            // released slot sits at LRU end
    runOp(1, 5, "R6");
    runOp(1, 5, "R6");
    z = -1;
    for (int i = 0; i < N; i++) if (pin[i] == 0 && z < 0) z = i;
    if (z < 0) begin doUnpin(7); z = (pin[7] == 0) ? 7 : 0; end
    doUnpin(z);                   // may underflow
    for (int i = 0; i < N; i++) if (pin[i] > 0) doUnpin(i);
    busyIn  = '1;
    strayOn = 1'b1;
    runOp(0, 0, "R10");           // stray refreshes during search ignored
    strayOn = 1'b0;
    busyIn  = '0;
    runOp(0, 0, "R10");

    for (int it = 0; it < 300; it++) begin
      busyIn = N'($urandom);
      pendingRelease = 1'($urandom_range(0, 1));
      r = $urandom_range(0, 9);
      s = $urandom_range(0, N - 1);
      if (r < 3) runOp(0, 0, "R2");
      else if (r < 5) begin
        if (pin[s] < 10) runOp(1, s, "R6");
      end
      else if (r == 5) runOp(2, 0, "R7");
      else if (r == 6) runOp(3, s, "R8");
      else begin
        for (int i = 0; i < N; i++) if (pin[(s + i) % N] > 0 && pin[s] == 0) s = (s + i) % N;
        doUnpin(s);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule